// File: doc/BRIEF.md
# Mode-Selected Clear-On-Read Error Counter

This block keeps a 16-bit tally of link errors that software reads through a register interface. Three error sources feed it: invalid received code words and disparity faults from the line decoder, errors from the test pattern checker, and errors from the PRBS checker. Which source is counted depends on the current operating mode. The PRBS checker wins over the test pattern checker, and the test pattern checker wins over the functional decoder path.

The count is always visible on the output. A read strobe takes the value shown in that cycle and clears the counter. An error that arrives in the same cycle as a read is not lost: it becomes the first count after the clear. The counter stops at its maximum value and does not wrap. After reset it holds 0xFFFD.

Top module: `err_tally`

## Requirements
- R1: After reset the count output is 0xFFFD.
- R2: When `prbs_chk_en` is 1, each cycle with `prbs_err` high adds one to the count, and `tpat_err`, `code_err` and `disp_err` have no effect.
- R3: When `tpat_chk_en` is 1 and `prbs_chk_en` is 0, each cycle with `tpat_err` high adds one, and `code_err`, `disp_err` and `prbs_err` have no effect.
- R4: When both checker enables are 0 and `line_dec_en` is 1, each cycle with `code_err` or `disp_err` high adds exactly one, even when both are high.
- R5: When all three enables are 0, no error strobe changes the count.
- R6: The count stays at 0xFFFF when a further counted error arrives and no read is made.
- R7: A cycle with `rd_stb` high and no counted error makes the count 0x0000 in the next cycle.
- R8: A cycle with `rd_stb` high and a counted error makes the count 0x0001 in the next cycle. The value on `cnt_o` in the read cycle is the count from before the read.
- R9: A counted error shows on `cnt_o` one clock after its strobe. Without a read or a counted error, the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_dec_en | input | 1 | Line decoder enabled (functional mode counting) |
| tpat_chk_en | input | 1 | Test pattern verification mode |
| prbs_chk_en | input | 1 | PRBS checking active (highest priority) |
| code_err | input | 1 | Invalid code word strobe from the decoder |
| disp_err | input | 1 | Disparity error strobe from the decoder |
| tpat_err | input | 1 | Test pattern checker error strobe |
| prbs_err | input | 1 | PRBS checker error strobe |
| rd_stb | input | 1 | Register read strobe; clears the counter |
| cnt_o | output | 16 | Current error count, returned by a read |

## Verification
A read and a counted error can fall in the same cycle. A saturated counter can also meet a read. The bench provokes both with directed cases first. It reads while a selected strobe is high, and it reads at 0xFFFF with and without an error. It then runs random cycles in which `rd_stb` and every strobe are often high together. In each read cycle it checks that `cnt_o` still shows the old count. In the next cycle it checks for 0x0001 when the selected source fired, and for 0x0000 otherwise.

// File: rtl/err_tally_pkg.sv
package err_tally_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_LINE = 2'd1,
        SRC_TPAT = 2'd2,
        SRC_PRBS = 2'd3
    } src_e;

    localparam int unsigned CNT_W_DEF = 16;

endpackage

// File: rtl/err_src_sel.sv
module err_src_sel
    import err_tally_pkg::*;
(
    input  logic line_dec_en,
    input  logic tpat_chk_en,
    input  logic prbs_chk_en,
    input  logic code_err,
    input  logic disp_err,
    input  logic tpat_err,
    input  logic prbs_err,
    output src_e src,
    output logic hit
);

    // fixed priority: PRBS > test pattern > functional decoder
    always_comb begin
        if (prbs_chk_en)       src = SRC_PRBS;
        else if (tpat_chk_en)  src = SRC_TPAT;
        else if (line_dec_en)  src = SRC_LINE;
        else                   src = SRC_NONE;
    end

    always_comb begin
        unique case (src)
            SRC_PRBS: hit = prbs_err;
            SRC_TPAT: hit = tpat_err;
            SRC_LINE: hit = code_err | disp_err; // one code word per cycle
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/err_tally_core.sv
module err_tally_core #(
    parameter int unsigned          W       = 16,
    parameter logic [W-1:0]         RST_VAL = 16'hFFFD
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit,
    input  logic         rd_stb,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] CNT_MAX = '1;
    localparam logic [W-1:0] CNT_ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_stb) begin
            st_d.cnt = hit ? CNT_ONE : '0;
        end else if (hit && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cnt: RST_VAL};
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/err_tally.sv
module err_tally
    import err_tally_pkg::*;
#(
    parameter int unsigned  CNT_W   = CNT_W_DEF,
    parameter logic [CNT_W-1:0] RST_VAL = 16'hFFFD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_dec_en,
    input  logic             tpat_chk_en,
    input  logic             prbs_chk_en,
    input  logic             code_err,
    input  logic             disp_err,
    input  logic             tpat_err,
    input  logic             prbs_err,
    input  logic             rd_stb,
    output logic [CNT_W-1:0] cnt_o
);

    src_e src;
    logic hit;

    err_src_sel u_sel (
        .line_dec_en (line_dec_en),
        .tpat_chk_en (tpat_chk_en),
        .prbs_chk_en (prbs_chk_en),
        .code_err    (code_err),
        .disp_err    (disp_err),
        .tpat_err    (tpat_err),
        .prbs_err    (prbs_err),
        .src         (src),
        .hit         (hit)
    );

    err_tally_core #(.W(CNT_W), .RST_VAL(RST_VAL)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .rd_stb (rd_stb),
        .cnt    (cnt_o)
    );

endmodule

// File: rtl/err_tally_chk.sv
module err_tally_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         line_dec_en,
    input logic         tpat_chk_en,
    input logic         prbs_chk_en,
    input logic         prbs_err,
    input logic         rd_stb,
    input logic         hit,
    input logic [W-1:0] cnt
);

    localparam logic [W-1:0] MAXV = '1;

    assert_prbs_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (prbs_chk_en && !prbs_err && !rd_stb) |=> $stable(cnt));

    assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!prbs_chk_en && !tpat_chk_en && !line_dec_en && !rd_stb) |=> $stable(cnt));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV && !rd_stb) |=> cnt == MAXV);

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !hit) |=> cnt == '0);

    assert_keep_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && hit) |=> cnt == W'(1));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb && !hit) |=> $stable(cnt));

    assert_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb && hit && cnt != MAXV) |=> cnt == $past(cnt) + W'(1));

endmodule

bind err_tally err_tally_chk #(.W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_dec_en (line_dec_en),
    .tpat_chk_en (tpat_chk_en),
    .prbs_chk_en (prbs_chk_en),
    .prbs_err    (prbs_err),
    .rd_stb      (rd_stb),
    .hit         (hit),
    .cnt         (cnt_o)
);

// File: tb/err_tally_bench.sv
module err_tally_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_en = 0, tp_en = 0, pr_en = 0;
    logic c_err = 0, d_err = 0, t_err = 0, p_err = 0, rd = 0;
    logic [15:0] cnt_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] model;

    always #10 clk = ~clk;

    err_tally u_err_tally (
        .clk (clk), .rst_n (rst_n),
        .line_dec_en (dec_en), .tpat_chk_en (tp_en), .prbs_chk_en (pr_en),
        .code_err (c_err), .disp_err (d_err), .tpat_err (t_err), .prbs_err (p_err),
        .rd_stb (rd), .cnt_o (cnt_o)
    );

    function automatic logic counted(logic de, logic te, logic pe,
                                     logic ce, logic se, logic tx, logic px);
        if (pe)      return px;
        else if (te) return tx;
        else if (de) return ce || se;
        return 1'b0;
    endfunction

    function automatic logic [15:0] next_cnt(logic [15:0] cur, logic hitv, logic r);
        if (r)    return hitv ? 16'd1 : 16'd0;
        if (hitv) return (cur == 16'hFFFF) ? cur : cur + 16'd1;
        return cur;
    endfunction

    task automatic chk(string tag, logic [15:0] exp);
        n_cmp++;
        if (cnt_o !== exp) begin
            n_bad++;
            $display("FAIL %s: cnt_o=%h expected %h", tag, cnt_o, exp);
        end
    endtask

    // drive at negedge, check the read value, then check after the edge
    task automatic step(string tag, logic de, logic te, logic pe,
                        logic ce, logic se, logic tx, logic px, logic r);
        logic h;
        @(negedge clk);
        dec_en = de; tp_en = te; pr_en = pe;
        c_err = ce; d_err = se; t_err = tx; p_err = px; rd = r;
        if (r) chk("R8 read value", model);
        h = counted(de, te, pe, ce, se, tx, px);
        model = next_cnt(model, h, r);
        @(posedge clk);
        #5;
        chk(tag, model);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: cycles=%0d expected %0d", 150000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model = 16'hFFFD;
        chk("R1 reset value", model);

        // functional mode counts up to saturation
        step("R4 code err", 1, 0, 0, 1, 0, 0, 0, 0);
        step("R4 disp err", 1, 0, 0, 0, 1, 0, 0, 0);
        step("R6 saturate", 1, 0, 0, 1, 1, 0, 0, 0);
        step("R6 saturate", 1, 0, 0, 0, 1, 0, 0, 0);
        step("R7 read at max", 1, 0, 0, 0, 0, 0, 0, 1);
        step("R4 both strobes one step", 1, 0, 0, 1, 1, 0, 0, 0);
        step("R9 hold", 1, 0, 0, 0, 0, 1, 1, 0);
        step("R5 decoder off", 0, 0, 0, 1, 1, 1, 1, 0);
        step("R2 prbs ignores others", 0, 1, 1, 1, 1, 1, 0, 0);
        step("R2 prbs counts", 1, 1, 1, 0, 0, 0, 1, 0);
        step("R3 tpat ignores others", 1, 1, 0, 1, 1, 0, 1, 0);
        step("R3 tpat counts", 0, 1, 0, 0, 0, 1, 0, 0);
        step("R8 read with error", 0, 1, 0, 0, 0, 1, 0, 1);
        step("R7 read clear", 0, 0, 1, 0, 0, 0, 0, 1);

        // drive to max, then read with an error pending
        model = cnt_o;
        for (int i = 0; i < 70000 && model != 16'hFFFF; i++)
            step("R9 climb", 0, 0, 1, 0, 0, 0, 1, 0);
        step("R6 hold at max", 0, 0, 1, 0, 0, 0, 1, 0);
        step("R8 read at max with error", 0, 0, 1, 0, 0, 0, 1, 1);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic de, te, pe, r;
            string tag;
            de = $urandom_range(0, 3) != 0;
            te = $urandom_range(0, 3) == 0;
            pe = $urandom_range(0, 3) == 0;
            r  = $urandom_range(0, 7) == 0;
            if (r)       tag = "R7/R8 random read";
            else if (pe) tag = "R2 random";
            else if (te) tag = "R3 random";
            else if (de) tag = "R4 random";
            else         tag = "R5 random";
            step(tag, de, te, pe, 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), r);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule